// File: doc/BRIEF.md
# Keyboard Controller Command Decoder

This block is the host-side decision logic of a PC-style keyboard controller. The host reaches it through a byte-wide write strobe with one select bit. The select bit picks between the data port and the command port. Command bytes are decoded at once. A command either pushes a reply byte, edits the mode or output-port register, moves the A20 gate, or requests a system reset. A few commands instead arm a pending-parameter code, and the next data-port write is then steered to the mode register, the output port, one of the two reply queues, or the aux device. When no code is pending, a data-port write goes to the keyboard device.

The status byte is always visible on `status_o`, so a command-port read has no side effects. Its two buffer-full bits follow two availability inputs that come from the reply queues outside this block. Reply pushes, device writes, the A20 level and the reset pulse all leave the block from registers. Each one appears on the clock edge that takes the write.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset, with both availability inputs low: status_o reads 0x18, the mode register is 0x03, the stored output port is 0xCF, a20_o is 1, and no push, device write or reset pulse is active.
- R2: Status bit3 becomes 1 after every command-port write and 0 after every data-port write. Status bit0 is 1 when either availability input is high. Status bit5 is 1 only when aux data is available and keyboard data is not. Bits 1, 6 and 7 read 0, and bit4 reads 1.
- R3: Command 0x20 pushes the mode byte on the keyboard queue. Command 0xC0 pushes 0x80 there. Command 0xD0 pushes the output port with bit4 replaced by status bit0 and bit5 replaced by status bit5.
- R4: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 each arm a pending target, and the next data write goes to that target. The targets are, in that order: the mode register, the output port, the keyboard queue, the aux queue, and the aux device. Only that one data write is redirected.
- R5: A data write with no pending target produces a keyboard-device write carrying the byte.
- R6: Command 0xAA sets status bit2 and pushes 0x55 on the keyboard queue. Commands 0xA9 and 0xAB each push 0x00 there.
- R7: Command 0xA7 sets mode bit5 and 0xA8 clears it. Command 0xAD sets mode bit4 and 0xAE clears it. No other mode bit changes.
- R8: Every command from 0xF0 to 0xFF with bit0 clear raises sys_reset_req for exactly one clock. A command in that range with bit0 set has no effect.
- R9: A data write to the output port drives a20_o from the byte's bit1. It also raises a one-clock sys_reset_req when the byte's bit0 is 0.
- R10: Command 0xDF sets a20_o and output-port bit1. Command 0xDD clears both.
- R11: Any other command byte changes no register except status bit3, and it does not cancel an armed pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_cmd | input | 1 | 1 selects the command port, 0 selects the data port |
| wr_byte | input | 8 | Written byte |
| kbd_avail | input | 1 | Keyboard reply queue holds data |
| aux_avail | input | 1 | Aux reply queue holds data |
| status_o | output | 8 | Status byte, as read on the command port |
| kq_push | output | 1 | Push kq_byte into the keyboard reply queue |
| kq_byte | output | 8 | Byte for the keyboard reply queue |
| aq_push | output | 1 | Push aq_byte into the aux reply queue |
| aq_byte | output | 8 | Byte for the aux reply queue |
| kdev_wr | output | 1 | Send dev_byte to the keyboard device |
| adev_wr | output | 1 | Send dev_byte to the aux device |
| dev_byte | output | 8 | Byte sent to a device |
| a20_o | output | 1 | A20 gate level (output port bit1) |
| sys_reset_req | output | 1 | One-clock system reset request |

## Verification
The bench goes after the two-phase commands. A design that failed to clear the pending target would steer every later data write to the mode register or a queue. A design that let an unrelated command clear it would send the parameter byte to the keyboard. The bench walks all sixteen pulse-group codes, since a decoder that matched only 0xFE or 0xFF would miss resets on the other even codes. It also reads the output port while each availability pattern is applied, because a design that returned the stored bits 4 and 5 would report stale buffer-full flags. Writes of 0x00 and 0x01 to the output port check that reset and A20 come from separate bits, so a swapped bit would show up as a wrong pulse or a wrong gate level.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MODE_RST   = 8'h03;
    localparam logic [BYTE_W-1:0] OUTP_RST   = 8'hCF;
    localparam logic [BYTE_W-1:0] INPORT_VAL = 8'h80;
    localparam logic [BYTE_W-1:0] SELFTEST_OK = 8'h55;
    localparam logic [BYTE_W-1:0] IFTEST_OK  = 8'h00;

    localparam int MODE_AUX_OFF_BIT = 5;
    localparam int MODE_KBD_OFF_BIT = 4;
    localparam int OUTP_RST_BIT     = 0;
    localparam int OUTP_A20_BIT     = 1;
    localparam int OUTP_KOBF_BIT    = 4;
    localparam int OUTP_AOBF_BIT    = 5;

    typedef enum logic [2:0] {
        PW_NONE,
        PW_MODE,
        PW_OUTP,
        PW_KQ,
        PW_AQ,
        PW_AUXDEV
    } pend_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_MODE,
        OP_RD_OUTP,
        OP_RD_INPORT,
        OP_ARM,
        OP_AUX_OFF,
        OP_AUX_ON,
        OP_KBD_OFF,
        OP_KBD_ON,
        OP_SELFTEST,
        OP_IFTEST,
        OP_A20_ON,
        OP_A20_OFF,
        OP_RESET
    } op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] outp;
        logic              selftest;
        logic              cmd_flag;
        pend_e             pend;
        logic              kq_push;
        logic [BYTE_W-1:0] kq_byte;
        logic              aq_push;
        logic [BYTE_W-1:0] aq_byte;
        logic              kdev_wr;
        logic              adev_wr;
        logic [BYTE_W-1:0] dev_byte;
        logic              rst_req;
    } kbc_state_t;
endpackage

// File: rtl/kbc_cmd_classify.sv
module kbc_cmd_classify
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output op_e               op,
    output pend_e             arm_code
);
    localparam logic [3:0] PULSE_NIB = 4'hF;

    always_comb begin
        op       = OP_NONE;
        arm_code = PW_NONE;
        if (cmd_byte[BYTE_W-1 -: 4] == PULSE_NIB) begin
            op = cmd_byte[0] ? OP_NONE : OP_RESET;
        end else begin
            unique case (cmd_byte)
                8'h20: op = OP_RD_MODE;
                8'hD0: op = OP_RD_OUTP;
                8'hC0: op = OP_RD_INPORT;
                8'h60: begin op = OP_ARM; arm_code = PW_MODE;   end
                8'hD1: begin op = OP_ARM; arm_code = PW_OUTP;   end
                8'hD2: begin op = OP_ARM; arm_code = PW_KQ;     end
                8'hD3: begin op = OP_ARM; arm_code = PW_AQ;     end
                8'hD4: begin op = OP_ARM; arm_code = PW_AUXDEV; end
                8'hA7: op = OP_AUX_OFF;
                8'hA8: op = OP_AUX_ON;
                8'hAD: op = OP_KBD_OFF;
                8'hAE: op = OP_KBD_ON;
                8'hAA: op = OP_SELFTEST;
                8'hA9, 8'hAB: op = OP_IFTEST;
                8'hDF: op = OP_A20_ON;
                8'hDD: op = OP_A20_OFF;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/kbc_obf_view.sv
module kbc_obf_view
    import kbc_pkg::*;
(
    input  logic              kbd_avail,
    input  logic              aux_avail,
    input  logic              selftest,
    input  logic              cmd_flag,
    input  logic [BYTE_W-1:0] outp_stored,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] outp_view
);
    localparam logic [BYTE_W-1:0] OBF_MASK =
        (BYTE_W'(1) << OUTP_KOBF_BIT) | (BYTE_W'(1) << OUTP_AOBF_BIT);

    logic any_obf;
    logic aux_obf;

    always_comb begin
        any_obf = kbd_avail | aux_avail;
        aux_obf = aux_avail & ~kbd_avail;
        status  = {1'b0, 1'b0, aux_obf, 1'b1, cmd_flag, selftest, 1'b0, any_obf};
        outp_view = (outp_stored & ~OBF_MASK)
                  | (BYTE_W'(any_obf) << OUTP_KOBF_BIT)
                  | (BYTE_W'(aux_obf) << OUTP_AOBF_BIT);
    end
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_cmd,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              kbd_avail,
    input  logic              aux_avail,
    output logic [BYTE_W-1:0] status_o,
    output logic              kq_push,
    output logic [BYTE_W-1:0] kq_byte,
    output logic              aq_push,
    output logic [BYTE_W-1:0] aq_byte,
    output logic              kdev_wr,
    output logic              adev_wr,
    output logic [BYTE_W-1:0] dev_byte,
    output logic              a20_o,
    output logic              sys_reset_req
);
    kbc_state_t        st_d, st_q;
    op_e               op;
    pend_e             arm_code;
    logic [BYTE_W-1:0] outp_view;

    kbc_cmd_classify i_classify (
        .cmd_byte (wr_byte),
        .op       (op),
        .arm_code (arm_code)
    );

    kbc_obf_view i_view (
        .kbd_avail   (kbd_avail),
        .aux_avail   (aux_avail),
        .selftest    (st_q.selftest),
        .cmd_flag    (st_q.cmd_flag),
        .outp_stored (st_q.outp),
        .status      (status_o),
        .outp_view   (outp_view)
    );

    always_comb begin
        st_d         = st_q;
        st_d.kq_push = 1'b0;
        st_d.aq_push = 1'b0;
        st_d.kdev_wr = 1'b0;
        st_d.adev_wr = 1'b0;
        st_d.rst_req = 1'b0;
        if (wr_en && wr_cmd) begin
            st_d.cmd_flag = 1'b1;
            unique case (op)
                OP_RD_MODE:   begin st_d.kq_push = 1'b1; st_d.kq_byte = st_q.mode; end
                OP_RD_OUTP:   begin st_d.kq_push = 1'b1; st_d.kq_byte = outp_view; end
                OP_RD_INPORT: begin st_d.kq_push = 1'b1; st_d.kq_byte = INPORT_VAL; end
                OP_ARM:       st_d.pend = arm_code;
                OP_AUX_OFF:   st_d.mode[MODE_AUX_OFF_BIT] = 1'b1;
                OP_AUX_ON:    st_d.mode[MODE_AUX_OFF_BIT] = 1'b0;
                OP_KBD_OFF:   st_d.mode[MODE_KBD_OFF_BIT] = 1'b1;
                OP_KBD_ON:    st_d.mode[MODE_KBD_OFF_BIT] = 1'b0;
                OP_SELFTEST: begin
                    st_d.selftest = 1'b1;
                    st_d.kq_push  = 1'b1;
                    st_d.kq_byte  = SELFTEST_OK;
                end
                OP_IFTEST:    begin st_d.kq_push = 1'b1; st_d.kq_byte = IFTEST_OK; end
                OP_A20_ON:    st_d.outp[OUTP_A20_BIT] = 1'b1;
                OP_A20_OFF:   st_d.outp[OUTP_A20_BIT] = 1'b0;
                OP_RESET:     st_d.rst_req = 1'b1;
                default: ;
            endcase
        end else if (wr_en) begin
            st_d.cmd_flag = 1'b0;
            st_d.pend     = PW_NONE;
            unique case (st_q.pend)
                PW_MODE: st_d.mode = wr_byte;
                PW_OUTP: begin
                    st_d.outp    = wr_byte;
                    st_d.rst_req = ~wr_byte[OUTP_RST_BIT];
                end
                PW_KQ:     begin st_d.kq_push = 1'b1; st_d.kq_byte = wr_byte; end
                PW_AQ:     begin st_d.aq_push = 1'b1; st_d.aq_byte = wr_byte; end
                PW_AUXDEV: begin st_d.adev_wr = 1'b1; st_d.dev_byte = wr_byte; end
                default:   begin st_d.kdev_wr = 1'b1; st_d.dev_byte = wr_byte; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_RST;
            st_q.outp     <= OUTP_RST;
            st_q.cmd_flag <= 1'b1;
            st_q.pend     <= PW_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign kq_push       = st_q.kq_push;
    assign kq_byte       = st_q.kq_byte;
    assign aq_push       = st_q.aq_push;
    assign aq_byte       = st_q.aq_byte;
    assign kdev_wr       = st_q.kdev_wr;
    assign adev_wr       = st_q.adev_wr;
    assign dev_byte      = st_q.dev_byte;
    assign a20_o         = st_q.outp[OUTP_A20_BIT];
    assign sys_reset_req = st_q.rst_req;
endmodule

// File: rtl/kbc_cmd_decoder_chk.sv
module kbc_cmd_decoder_chk
    import kbc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_cmd,
    input logic [BYTE_W-1:0] status_o,
    input logic              kq_push,
    input logic              aq_push,
    input logic              kdev_wr,
    input logic              adev_wr,
    input logic              a20_o,
    input logic              sys_reset_req
);
    // R4, R5: each write produces at most one destination.
    p_one_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kq_push, aq_push, kdev_wr, adev_wr}));

    // R2: the command flag follows the port of the last write.
    p_cmd_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd) |=> status_o[3]);
    p_cmd_flag_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_cmd) |=> !status_o[3]);

    // R8: the reset pulse only ever follows a write.
    p_reset_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !sys_reset_req);

    // R11: an idle cycle produces no push or device write.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !(kq_push || aq_push || kdev_wr || adev_wr));

    // R10: the A20 level moves only on a write.
    p_a20_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(a20_o));

    // R5: a keyboard-device write comes only from a data-port write.
    p_kdev_from_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kdev_wr |-> $past(wr_en && !wr_cmd));
endmodule

bind kbc_cmd_decoder kbc_cmd_decoder_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_cmd        (wr_cmd),
    .status_o      (status_o),
    .kq_push       (kq_push),
    .aq_push       (aq_push),
    .kdev_wr       (kdev_wr),
    .adev_wr       (adev_wr),
    .a20_o         (a20_o),
    .sys_reset_req (sys_reset_req)
);

// File: tb/test_kbc_cmd_decoder.sv
`timescale 1ns/1ps
module test_kbc_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       kbd_avail = 1'b0;
    logic       aux_avail = 1'b0;
    logic [7:0] status_o;
    logic       kq_push, aq_push, kdev_wr, adev_wr, a20_o, sys_reset_req;
    logic [7:0] kq_byte, aq_byte, dev_byte;

    always #2 clk = ~clk;

    kbc_cmd_decoder i_kbc_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_byte(wr_byte),
        .kbd_avail(kbd_avail), .aux_avail(aux_avail), .status_o(status_o),
        .kq_push(kq_push), .kq_byte(kq_byte), .aq_push(aq_push), .aq_byte(aq_byte),
        .kdev_wr(kdev_wr), .adev_wr(adev_wr), .dev_byte(dev_byte),
        .a20_o(a20_o), .sys_reset_req(sys_reset_req)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int  m_mode = 8'h03;
    int  m_outp = 8'hCF;
    bit  m_self = 0;
    bit  m_flag = 1;
    int  m_pend = 0;   // 0 none, 'h60, 'hD1, 'hD2, 'hD3, 'hD4
    bit  e_kq, e_aq, e_kd, e_ad, e_rst;
    int  e_kqb, e_aqb, e_devb;

    function automatic int obf_any();
        return (kbd_avail || aux_avail) ? 1 : 0;
    endfunction
    function automatic int obf_aux();
        return (aux_avail && !kbd_avail) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input bit w, input bit c, input int b);
        e_kq = 0; e_aq = 0; e_kd = 0; e_ad = 0; e_rst = 0;
        if (!w) return;
        if (c) begin
            m_flag = 1;
            if ((b & 'hF0) == 'hF0) begin
                e_rst = ((b & 1) == 0);
            end else begin
                case (b)
                    'h20: begin e_kq = 1; e_kqb = m_mode; end
                    'hD0: begin e_kq = 1; e_kqb = (m_outp & 'hCF) | (obf_any() << 4) | (obf_aux() << 5); end
                    'hC0: begin e_kq = 1; e_kqb = 'h80; end
                    'h60, 'hD1, 'hD2, 'hD3, 'hD4: m_pend = b;
                    'hA7: m_mode = m_mode | 'h20;
                    'hA8: m_mode = m_mode & ~'h20;
                    'hAD: m_mode = m_mode | 'h10;
                    'hAE: m_mode = m_mode & ~'h10;
                    'hAA: begin m_self = 1; e_kq = 1; e_kqb = 'h55; end
                    'hA9, 'hAB: begin e_kq = 1; e_kqb = 'h00; end
                    'hDF: m_outp = m_outp | 'h02;
                    'hDD: m_outp = m_outp & ~'h02;
                    default: ;
                endcase
            end
        end else begin
            m_flag = 0;
            case (m_pend)
                'h60: m_mode = b;
                'hD1: begin m_outp = b; e_rst = ((b & 1) == 0); end
                'hD2: begin e_kq = 1; e_kqb = b; end
                'hD3: begin e_aq = 1; e_aqb = b; end
                'hD4: begin e_ad = 1; e_devb = b; end
                default: begin e_kd = 1; e_devb = b; end
            endcase
            m_pend = 0;
        end
    endtask

    task automatic compare(input string req);
        int exp_st;
        exp_st = (obf_aux() << 5) | 'h10 | (int'(m_flag) << 3) | (int'(m_self) << 2) | obf_any();
        check(req, "status", status_o, exp_st);
        check(req, "kq_push", kq_push, e_kq);
        if (e_kq) check(req, "kq_byte", kq_byte, e_kqb);
        check(req, "aq_push", aq_push, e_aq);
        if (e_aq) check(req, "aq_byte", aq_byte, e_aqb);
        check(req, "kdev_wr", kdev_wr, e_kd);
        check(req, "adev_wr", adev_wr, e_ad);
        if (e_kd || e_ad) check(req, "dev_byte", dev_byte, e_devb);
        check(req, "a20", a20_o, (m_outp >> 1) & 1);
        check(req, "reset_req", sys_reset_req, e_rst);
    endtask

    task automatic cyc(input bit w, input bit c, input int b, input string req);
        wr_en = w; wr_cmd = c; wr_byte = b[7:0];
        @(posedge clk);
        model(w, c, b);
        @(negedge clk);
        compare(req);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input int b, input string req);
        cyc(1, 1, b, req);
        cyc(0, 0, 0, req);
    endtask

    task automatic dat(input int b, input string req);
        cyc(1, 0, b, req);
        cyc(0, 0, 0, req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1");
        // R1 reset contents read back
        cmd('h20, "R1");
        cmd('hD0, "R1");
        // R3 input port
        cmd('hC0, "R3");
        // R2 availability patterns, R3 output-port view
        kbd_avail = 1; cyc(0, 0, 0, "R2"); cmd('hD0, "R3");
        aux_avail = 1; cyc(0, 0, 0, "R2"); cmd('hD0, "R3");
        kbd_avail = 0; cyc(0, 0, 0, "R2"); cmd('hD0, "R3");
        aux_avail = 0; cyc(0, 0, 0, "R2");
        // R6 tests
        cmd('hA9, "R6"); cmd('hAB, "R6"); cmd('hAA, "R6");
        // R7 mode bits
        cmd('hA7, "R7"); cmd('h20, "R7");
        cmd('hAD, "R7"); cmd('h20, "R7");
        cmd('hA8, "R7"); cmd('h20, "R7");
        cmd('hAE, "R7"); cmd('h20, "R7");
        // R4 two-phase commands, R5 default route
        cmd('h60, "R4"); dat('h45, "R4"); cmd('h20, "R4"); dat('h46, "R4");
        cmd('hD2, "R4"); dat('h9C, "R4"); dat('h9D, "R5");
        cmd('hD3, "R4"); dat('h3E, "R4");
        cmd('hD4, "R4"); dat('hF4, "R4");
        dat('hED, "R5");
        // back-to-back writes with no idle gap
        cyc(1, 1, 'hD2, "R4"); cyc(1, 0, 'h11, "R4"); cyc(1, 0, 'h12, "R5");
        cyc(0, 0, 0, "R2");
        // R9 output-port writes
        cmd('hD1, "R9"); dat('h01, "R9"); cmd('hD0, "R9");
        cmd('hD1, "R9"); dat('h00, "R9");
        cmd('hD1, "R9"); dat('h03, "R9"); cmd('hD0, "R9");
        // R10 A20 commands
        cmd('hDD, "R10"); cmd('hD0, "R10");
        cmd('hDF, "R10"); cmd('hD0, "R10");
        // R8 pulse group
        for (int i = 'hF0; i <= 'hFF; i++) cmd(i, "R8");
        cyc(1, 1, 'hFE, "R8"); cyc(1, 1, 'hFF, "R8"); cyc(0, 0, 0, "R8");
        // R11 unknown commands
        cmd('hA1, "R11"); cmd('h00, "R11"); cmd('hB5, "R11");
        cmd('h20, "R11"); cmd('hD0, "R11");
        cmd('h60, "R11"); cmd('hA1, "R11"); cmd('hC0, "R11"); dat('h11, "R11");
        cmd('h20, "R11");
        cmd('hD4, "R11"); cmd('hFF, "R11"); dat('h77, "R11");
        repeat (3) cyc(0, 0, 0, "R11");
        finish_run();
    end
endmodule